// File: doc/BRIEF.md
# Grouped Interrupt Status Aggregator

This block folds a wide field of per-pin pending flags into a compact summary vector and one shared interrupt line to the processor. Each pin offers two sources, an interrupt-status flag and a wake-status flag, and a pin counts as pending when either is set. Pins are gathered in fixed groups of four consecutive pins, and each group sets one summary bit. With the default 184 pins this gives 46 summary bits.

Software reads the summary through a small read port as two 32-bit words. It then visits only the groups whose bits are set. When servicing is done it writes an end-of-interrupt command to a control word. That write forces the shared line low for one cycle. If any pin is still pending, the line rises again on the following cycle, so a source that stays active or arrives during servicing always produces a fresh rising edge.

Top module: `irq_group_aggregator`

## Requirements
- R1: A pin is pending when its interrupt-status input, its wake-status input, or both are 1.
- R2: Summary bit g is 1 exactly when at least one of pins 4g, 4g+1, 4g+2, 4g+3 is pending. The summary is registered, so it reflects the pin inputs sampled at the previous rising clock edge.
- R3: A read with address 0 returns summary bits 31..0 on data bits 31..0.
- R4: A read with address 1 returns summary bits 45..32 on data bits 13..0, and data bits 31..14 read as 0.
- R5: Outside an end-of-interrupt cycle, the interrupt output is 1 in the cycle after any pin was pending, and 0 in the cycle after no pin was pending.
- R6: A control write with data bit 29 set is an end-of-interrupt command. The interrupt output is 0 in the following cycle and, if a pin is still pending, returns to 1 one cycle later.
- R7: A control write with data bit 29 clear has no effect on the interrupt output.
- R8: The end-of-interrupt bit is not stored. A read with address 2 (control word) returns 0, also right after an end-of-interrupt write. Address 3 also returns 0.
- R9: While the synchronous active-high reset is 1, the summary and the interrupt output are held at 0 whatever the pin inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_irq_sts | input | NUM_PINS | Per-pin interrupt-status flags |
| pin_wake_sts | input | NUM_PINS | Per-pin wake-status flags |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control write data; bit 29 commands end of interrupt |
| rd_addr | input | 2 | Read select: 0 summary low, 1 summary high, 2 control, 3 reserved |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_out | output | 1 | Shared interrupt line to the processor |

## Verification
Single pins are placed at both ends of a group and on either side of every word boundary: pins 0, 3, 4, 127, 128 and 183, using each source flag on its own. This separates an off-by-one group index or a swapped source from correct folding. A full field, an alternating field on one source only, and a mixed field show that the high word holds exactly 14 valid bits and that the unused upper bits stay at 0. End-of-interrupt writes are issued while a pin remains pending and with no pin pending, and a control write without the command bit is issued as well. Together these separate a real one-cycle drop and re-arm from a line that ignores the command or latches it.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        RD_SUM_LO = 2'd0,
        RD_SUM_HI = 2'd1,
        RD_CTRL   = 2'd2,
        RD_RSVD   = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic eoi;
        logic any_pending;
    } irq_evt_t;

    function automatic int unsigned groups_for(input int unsigned pins, input int unsigned per);
        return (pins + per - 1) / per;
    endfunction

endpackage

// File: rtl/irqagg_group_or.sv
module irqagg_group_or #(
    parameter int NUM_PINS   = 184,
    parameter int PER_GROUP  = 4,
    parameter int NUM_GROUPS = 46
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PINS-1:0]   irq_sts,
    input  logic [NUM_PINS-1:0]   wake_sts,
    output logic [NUM_GROUPS-1:0] sum_q,
    output logic                  any_next
);
    localparam int PAD_W = NUM_GROUPS * PER_GROUP;

    logic [PAD_W-1:0]      pend_pad;
    logic [NUM_GROUPS-1:0] grp_next;

    always_comb begin
        pend_pad = '0;
        pend_pad[NUM_PINS-1:0] = irq_sts | wake_sts;
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_fold
        assign grp_next[g] = |pend_pad[g*PER_GROUP +: PER_GROUP];
    end

    assign any_next = |grp_next;

    always_ff @(posedge clk) begin
        if (rst) sum_q <= '0;
        else     sum_q <= grp_next;
    end

    AST_SUM_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(|(irq_sts | wake_sts)) |=> (sum_q == '0)); // R2

    AST_SUM_RST: assert property (@(posedge clk)
        rst |=> (sum_q == '0)); // R9

endmodule

// File: rtl/irqagg_readout.sv
module irqagg_readout
    import irqagg_pkg::*;
#(
    parameter int NUM_GROUPS = 46
) (
    input  logic [NUM_GROUPS-1:0] sum_q,
    input  rd_sel_e               sel,
    output logic [WORD_W-1:0]     rd_data
);
    localparam int SUM_W = 2 * WORD_W;

    logic [SUM_W-1:0] sum_ext;

    assign sum_ext = SUM_W'(sum_q);

    always_comb begin
        unique case (sel)
            RD_SUM_LO: rd_data = sum_ext[WORD_W-1:0];
            RD_SUM_HI: rd_data = sum_ext[SUM_W-1:WORD_W];
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irqagg_irq_ctl.sv
module irqagg_irq_ctl
    import irqagg_pkg::*;
#(
    parameter int EOI_BIT = 29
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [WORD_W-1:0] ctrl_wdata,
    input  logic              any_next,
    output logic              irq_q
);
    irq_evt_t evt;

    always_comb begin
        evt.eoi         = ctrl_wr & ctrl_wdata[EOI_BIT];
        evt.any_pending = any_next;
    end

    always_ff @(posedge clk) begin
        if (rst)          irq_q <= 1'b0;
        else if (evt.eoi) irq_q <= 1'b0;
        else              irq_q <= evt.any_pending;
    end

    AST_EOI_DROP: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_wdata[EOI_BIT]) |=> !irq_q); // R6

    AST_PEND_RAISE: assert property (@(posedge clk) disable iff (rst)
        (any_next && !(ctrl_wr && ctrl_wdata[EOI_BIT])) |=> irq_q); // R5

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !any_next |=> !irq_q); // R5

    AST_IRQ_RST: assert property (@(posedge clk)
        rst |=> !irq_q); // R9

endmodule

// File: rtl/irq_group_aggregator.sv
module irq_group_aggregator
    import irqagg_pkg::*;
#(
    parameter int NUM_PINS  = 184,
    parameter int PER_GROUP = 4,
    parameter int EOI_BIT   = 29
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_irq_sts,
    input  logic [NUM_PINS-1:0] pin_wake_sts,
    input  logic                ctrl_wr,
    input  logic [WORD_W-1:0]   ctrl_wdata,
    input  logic [1:0]          rd_addr,
    output logic [WORD_W-1:0]   rd_data,
    output logic                irq_out
);
    localparam int NUM_GROUPS = groups_for(NUM_PINS, PER_GROUP);
    localparam int HI_BITS    = NUM_GROUPS - WORD_W;

    logic [NUM_GROUPS-1:0] sum_w;
    logic                  any_w;
    rd_sel_e               sel_w;

    assign sel_w = rd_sel_e'(rd_addr);

    irqagg_group_or #(
        .NUM_PINS   (NUM_PINS),
        .PER_GROUP  (PER_GROUP),
        .NUM_GROUPS (NUM_GROUPS)
    ) u_fold (
        .clk      (clk),
        .rst      (rst),
        .irq_sts  (pin_irq_sts),
        .wake_sts (pin_wake_sts),
        .sum_q    (sum_w),
        .any_next (any_w)
    );

    irqagg_readout #(
        .NUM_GROUPS (NUM_GROUPS)
    ) u_rd (
        .sum_q   (sum_w),
        .sel     (sel_w),
        .rd_data (rd_data)
    );

    irqagg_irq_ctl #(
        .EOI_BIT (EOI_BIT)
    ) u_irq (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .any_next   (any_w),
        .irq_q      (irq_out)
    );

    AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel_w == RD_SUM_HI) |-> (rd_data[WORD_W-1:HI_BITS] == '0)); // R4

    AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel_w == RD_CTRL || sel_w == RD_RSVD) |-> (rd_data == '0)); // R8

    AST_NOEOI_KEEP: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !ctrl_wdata[EOI_BIT] && irq_out && any_w) |=> irq_out); // R7

endmodule

// File: tb/sim_irq_group_aggregator.sv
`timescale 1ns/1ps
module sim_irq_group_aggregator;
    localparam int NP  = 184;
    localparam int EOI = 29;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] irq_s;
    logic [NP-1:0] wake_s;
    logic          ctrl_wr;
    logic [31:0]   ctrl_wdata;
    logic [1:0]    rd_addr;
    logic [31:0]   rd_data;
    logic          irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_group_aggregator u0 (
        .clk          (clk),
        .rst          (rst),
        .pin_irq_sts  (irq_s),
        .pin_wake_sts (wake_s),
        .ctrl_wr      (ctrl_wr),
        .ctrl_wdata   (ctrl_wdata),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .irq_out      (irq_out)
    );

    function automatic logic [63:0] ref_sum(input logic [NP-1:0] a, input logic [NP-1:0] b);
        logic [63:0] r = '0;
        for (int p = 0; p < NP; p++)
            if (a[p] | b[p]) r[p/4] = 1'b1;
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_word(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // Drive a pin field, let one edge pass, then compare both words and the line
    task automatic apply_field(input string tag, input logic [NP-1:0] a, input logic [NP-1:0] b);
        logic [63:0] e;
        logic [31:0] d;
        @(negedge clk);
        irq_s  = a;
        wake_s = b;
        @(negedge clk);
        e = ref_sum(a, b);
        rd_word(2'd0, d);
        chk({tag, " R1 R2 R3 low word"}, d, e[31:0]);
        rd_word(2'd1, d);
        chk({tag, " R2 R4 high word"}, d, e[63:32]);
        chk({tag, " R5 irq line"}, {31'd0, irq_out}, {31'd0, |e});
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rst = 1'b1; ctrl_wr = 1'b0; ctrl_wdata = '0; rd_addr = 2'd0;
        irq_s = '1; wake_s = '1;
        repeat (3) @(negedge clk);
        rd_word(2'd0, d); chk("R9 low word in reset", d, 32'd0);
        rd_word(2'd1, d); chk("R9 high word in reset", d, 32'd0);
        chk("R9 irq in reset", {31'd0, irq_out}, 32'd0);
        irq_s = '0; wake_s = '0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R5 irq idle after reset", {31'd0, irq_out}, 32'd0);
    endtask

    task automatic t_single_pins;
        logic [NP-1:0] one;
        one = '0; one[0] = 1'b1;   apply_field("pin0 int", one, '0);
        one = '0; one[3] = 1'b1;   apply_field("pin3 wake", '0, one);
        one = '0; one[4] = 1'b1;   apply_field("pin4 int", one, '0);
        one = '0; one[127] = 1'b1; apply_field("pin127 wake", '0, one);
        one = '0; one[128] = 1'b1; apply_field("pin128 int", one, '0);
        one = '0; one[183] = 1'b1; apply_field("pin183 wake", '0, one);
        apply_field("empty", '0, '0);
    endtask

    task automatic t_fields;
        logic [NP-1:0] alt;
        logic [NP-1:0] mix;
        for (int i = 0; i < NP; i++) alt[i] = (i % 8) == 1;
        for (int i = 0; i < NP; i++) mix[i] = ((i * 7) % 13) == 0;
        apply_field("all ones", '1, '1);
        apply_field("alt int only", alt, '0);
        apply_field("mixed sources", mix, alt);
        apply_field("empty again", '0, '0);
    endtask

    task automatic t_eoi;
        logic [NP-1:0] one;
        logic [31:0]   d;
        one = '0; one[10] = 1'b1;
        apply_field("eoi setup", one, '0);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_wdata = 32'd1 << EOI;
        @(negedge clk);
        chk("R6 eoi drops line", {31'd0, irq_out}, 32'd0);
        rd_word(2'd2, d); chk("R8 ctrl read right after eoi", d, 32'd0);
        ctrl_wr = 1'b0; ctrl_wdata = '0;
        @(negedge clk);
        chk("R6 line rearms while pending", {31'd0, irq_out}, 32'd1);
        // non-eoi control write leaves the line alone
        ctrl_wr = 1'b1; ctrl_wdata = ~(32'd1 << EOI);
        @(negedge clk);
        chk("R7 write without eoi bit", {31'd0, irq_out}, 32'd1);
        rd_word(2'd2, d); chk("R8 ctrl read after plain write", d, 32'd0);
        rd_word(2'd3, d); chk("R8 reserved address", d, 32'd0);
        ctrl_wr = 1'b0; ctrl_wdata = '0;
        // clear the source, then eoi with nothing pending
        irq_s = '0;
        @(negedge clk);
        chk("R5 line falls after clear", {31'd0, irq_out}, 32'd0);
        ctrl_wr = 1'b1; ctrl_wdata = 32'd1 << EOI;
        @(negedge clk);
        ctrl_wr = 1'b0; ctrl_wdata = '0;
        @(negedge clk);
        chk("R6 no rearm when idle", {31'd0, irq_out}, 32'd0);
        // source arrives in the same cycle as eoi
        wake_s = '0; wake_s[50] = 1'b1;
        ctrl_wr = 1'b1; ctrl_wdata = 32'd1 << EOI;
        @(negedge clk);
        chk("R6 eoi wins over new source", {31'd0, irq_out}, 32'd0);
        ctrl_wr = 1'b0; ctrl_wdata = '0;
        @(negedge clk);
        chk("R6 new source rearms", {31'd0, irq_out}, 32'd1);
        rd_word(2'd1, d); chk("R1 R4 wake pin50 high word", d, 32'd0);
        rd_word(2'd0, d); chk("R1 R3 wake pin50 low word", d, 32'd1 << 12);
        wake_s = '0;
    endtask

    initial begin
        t_reset();
        t_single_pins();
        t_fields();
        t_eoi();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1600000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule